// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives the timing side of a TFT panel. It divides the system clock down to a pixel rate and walks a pixel position across each line and a line position down each frame. From those positions it produces horizontal sync, vertical sync, data-enable, a one-cycle pixel strobe, a pixel clock for the panel and the zero-based coordinates of the active pixel. Fetching pixel data is the job of a neighbouring block, which uses the strobe and the coordinates.

The geometry is programmed through three packed configuration words. Most fields use an offset-by-one encoding. The active width is counted in groups of 16 pixels. The vertical porches are raw line counts, so a porch of zero lines is allowed. Several fields are wider than the slot they occupy in their main word, and their high bits sit in an extension word.

The configuration words and the divisor are captured into shadow registers. While the block is disabled, the shadow registers follow the inputs on every cycle. While it runs, they are loaded only at the last strobe of a frame, so a frame that is in progress keeps the settings it started with. Separate polarity inputs take effect at once and can invert either sync output and the panel clock.

Top module: `lcd_raster_timing`

## Requirements
- R1: `pix_stb` is high for one system clock in every D clocks, where D is the effective divisor, and is never high on two cycles in a row. A pixel period runs from counter value 0 to D-1, and `pix_stb` is high on the last clock of the period. `lcd_pclk` is high for the first floor(D/2) clocks of each period and low for the rest. `inv_pclk`=1 inverts `lcd_pclk`.
- R2: A line is made of four parts, in this order: sync for `{cfg_x[3:0],cfg_h[12:7]}`+1 pixel periods, back porch for `{cfg_x[5:4],cfg_h[20:13]}`+1, active for 16*(`cfg_h[6:0]`+1), and front porch for `{cfg_x[7:6],cfg_h[28:21]}`+1. The horizontal sync output is asserted during the sync part.
- R3: A frame is made of four parts, in this order: sync for `cfg_v[15:10]`+1 lines, back porch for `cfg_v[23:16]` lines, active for `{cfg_x[8],cfg_v[9:0]}`+1 lines, and front porch for `cfg_v[31:24]` lines. A porch of zero lines is skipped. The vertical sync output is asserted during the sync lines.
- R4: `de` is high only where the active part of the line and the active part of the frame overlap. There, `pix_x` and `pix_y` give the zero-based pixel and line within the active area. Everywhere else both are 0.
- R5: `hsync` equals the horizontal sync state XOR `inv_hsync`, and `vsync` equals the vertical sync state XOR `inv_vsync`. Both apply in the same cycle, with no delay.
- R6: While the block runs, changes to `cfg_h`, `cfg_v`, `cfg_x` and `clk_div` have no effect until the clock after the last strobe of the current frame.
- R7: While `enable` is low: the pixel, line and divider positions are held at zero; `de`, `pix_stb`, `pix_x` and `pix_y` are 0; the syncs sit at their inactive level; and the configuration is captured on every cycle. The first clock with `enable` high starts a frame at pixel 0 of line 0.
- R8: A `clk_div` value of 0 or 1 behaves as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster; low holds the timing at frame start |
| clk_div | input | 8 | System clocks per pixel (values below 2 act as 2) |
| cfg_h | input | 29 | Horizontal word: width/16-1, sync, back porch and front porch low bits |
| cfg_v | input | 32 | Vertical word: lines-1 low bits, vsync-1, back porch, front porch |
| cfg_x | input | 9 | Extension: high bits of horizontal sync and porches, bit 10 of lines-1 |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_pclk | input | 1 | Invert panel pixel clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_stb | output | 1 | One-cycle pixel advance strobe |
| lcd_pclk | output | 1 | Panel pixel clock |
| pix_x | output | 13 | Active pixel column |
| pix_y | output | 13 | Active line row |

## Verification
The bench changes the geometry part-way through a frame. A design that loaded its shadow registers too early would show a line or frame length that matches neither the old nor the new settings. Zero-line vertical porches are tested: a design that added the usual minus-one offset to them would insert a stray blank line, or wrap the porch around. Divisors of 0 and 1 are tested as well, and a divider without the clamp would strobe on every clock or stall. Horizontal fields whose high bits sit in the extension word are exercised too, so a wrong splice point moves the active window by hundreds of pixels.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int CW    = 13;  // position / length width
  localparam int DW    = 8;   // divisor width
  localparam int HWW   = 29;  // horizontal word width
  localparam int VWW   = 32;  // vertical word width
  localparam int XWW   = 9;   // extension word width

  typedef struct packed {
    logic [CW-1:0] hs;
    logic [CW-1:0] hb;
    logic [CW-1:0] ha;
    logic [CW-1:0] hf;
    logic [CW-1:0] vs;
    logic [CW-1:0] vb;
    logic [CW-1:0] va;
    logic [CW-1:0] vf;
  } geom_t;

  function automatic geom_t decode_geom(logic [HWW-1:0] h, logic [VWW-1:0] v,
                                        logic [XWW-1:0] x);
    geom_t g;
    g.hs = {{(CW-10){1'b0}}, x[3:0], h[12:7]} + CW'(1);
    g.hb = {{(CW-10){1'b0}}, x[5:4], h[20:13]} + CW'(1);
    g.hf = {{(CW-10){1'b0}}, x[7:6], h[28:21]} + CW'(1);
    g.ha = ({{(CW-7){1'b0}}, h[6:0]} + CW'(1)) << 4;
    g.vs = {{(CW-6){1'b0}}, v[15:10]} + CW'(1);
    g.vb = {{(CW-8){1'b0}}, v[23:16]};
    g.vf = {{(CW-8){1'b0}}, v[31:24]};
    g.va = {{(CW-11){1'b0}}, x[8], v[9:0]} + CW'(1);
    return g;
  endfunction
endpackage

// File: rtl/lrt_pixclk.sv
module lrt_pixclk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          stb,
  output logic          pclk_hi
);
  localparam logic [DW-1:0] MIN_DIV = DW'(2);

  logic [DW-1:0] d_eff;
  logic [DW-1:0] cnt;

  assign d_eff   = (div < MIN_DIV) ? MIN_DIV : div;
  assign stb     = run && (cnt == d_eff - DW'(1));
  assign pclk_hi = run && (cnt < (d_eff >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || stb) cnt <= '0;
    else                 cnt <= cnt + DW'(1);
  end

  // R1 / R8: with an effective divisor of at least 2 strobes never touch
  a_r1_no_adjacent_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/lrt_axis.sv
module lrt_axis #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  output logic          in_sync,
  output logic          in_act,
  output logic          last,
  output logic [CW-1:0] coord
);
  logic [CW-1:0] pos;
  logic [CW-1:0] act_lo;
  logic [CW-1:0] act_hi;
  logic [CW-1:0] total;

  assign act_lo  = len_sync + len_back;
  assign act_hi  = act_lo + len_act;
  assign total   = act_hi + len_front;
  assign last    = step && (pos == total - CW'(1));
  assign in_sync = run && (pos < len_sync);
  assign in_act  = run && (pos >= act_lo) && (pos < act_hi);
  assign coord   = in_act ? (pos - act_lo) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pos <= '0;
    else if (last)      pos <= '0;
    else if (step)      pos <= pos + CW'(1);
  end

  // R2 / R3: position never leaves the programmed period
  a_r2_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < total));
  // R4: coordinate stays inside the active extent
  a_r4_coord_in_extent: assert property (@(posedge clk) disable iff (!rst_n)
    in_act |-> (coord < len_act));
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lrt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [DW-1:0]  clk_div,
  input  logic [HWW-1:0] cfg_h,
  input  logic [VWW-1:0] cfg_v,
  input  logic [XWW-1:0] cfg_x,
  input  logic           inv_hsync,
  input  logic           inv_vsync,
  input  logic           inv_pclk,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic           pix_stb,
  output logic           lcd_pclk,
  output logic [CW-1:0]  pix_x,
  output logic [CW-1:0]  pix_y
);
  logic [HWW-1:0] sh_h;
  logic [VWW-1:0] sh_v;
  logic [XWW-1:0] sh_x;
  logic [DW-1:0]  sh_div;
  geom_t          geom;
  logic           stb, pclk_hi;
  logic           h_sync, h_act, h_last;
  logic           v_sync, v_act, v_last;
  logic [CW-1:0]  h_coord, v_coord;
  logic           load;

  assign geom = decode_geom(sh_h, sh_v, sh_x);
  assign load = !enable || v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_h <= '0; sh_v <= '0; sh_x <= '0; sh_div <= '0;
    end else if (load) begin
      sh_h <= cfg_h; sh_v <= cfg_v; sh_x <= cfg_x; sh_div <= clk_div;
    end
  end

  lrt_pixclk #(.DW(DW)) u_pixclk (
    .clk(clk), .rst_n(rst_n), .run(enable), .div(sh_div),
    .stb(stb), .pclk_hi(pclk_hi)
  );

  lrt_axis #(.CW(CW)) u_haxis (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(stb),
    .len_sync(geom.hs), .len_back(geom.hb), .len_act(geom.ha), .len_front(geom.hf),
    .in_sync(h_sync), .in_act(h_act), .last(h_last), .coord(h_coord)
  );

  lrt_axis #(.CW(CW)) u_vaxis (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(h_last),
    .len_sync(geom.vs), .len_back(geom.vb), .len_act(geom.va), .len_front(geom.vf),
    .in_sync(v_sync), .in_act(v_act), .last(v_last), .coord(v_coord)
  );

  assign hsync    = h_sync ^ inv_hsync;
  assign vsync    = v_sync ^ inv_vsync;
  assign de       = h_act && v_act;
  assign pix_stb  = stb;
  assign lcd_pclk = pclk_hi ^ inv_pclk;
  assign pix_x    = de ? h_coord : '0;
  assign pix_y    = de ? v_coord : '0;

  // R4: active video never overlaps a sync interval
  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!h_sync && !v_sync));
  // R6: running shadow copy only moves at a frame boundary
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(v_last)) |-> ($stable(sh_h) && $stable(sh_v)
      && $stable(sh_x) && $stable(sh_div)));
  // R7: idle block shows no video and no strobe
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!de && !pix_stb));
endmodule

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [7:0]  clk_div = 8'd2;
  logic [28:0] cfg_h = '0;
  logic [31:0] cfg_v = '0;
  logic [8:0]  cfg_x = '0;
  logic        inv_hsync = 0, inv_vsync = 0, inv_pclk = 0;
  logic        hsync, vsync, de, pix_stb, lcd_pclk;
  logic [12:0] pix_x, pix_y;

  int tests = 0, fails = 0, cycles = 0;
  string scen = "R7";

  always #2.5 clk = ~clk;

  lcd_raster_timing u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
    .cfg_h(cfg_h), .cfg_v(cfg_v), .cfg_x(cfg_x),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_pclk(inv_pclk),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_stb(pix_stb),
    .lcd_pclk(lcd_pclk), .pix_x(pix_x), .pix_y(pix_y)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt = 0, m_h = 0, m_v = 0, m_div = 0;
  logic [28:0] m_sh_h = '0;
  logic [31:0] m_sh_v = '0;
  logic [8:0]  m_sh_x = '0;

  function automatic int f_hs(logic [28:0] h, logic [8:0] x); return int'(x[3:0]) * 64 + int'(h[12:7]) + 1; endfunction
  function automatic int f_hb(logic [28:0] h, logic [8:0] x); return int'(x[5:4]) * 256 + int'(h[20:13]) + 1; endfunction
  function automatic int f_hf(logic [28:0] h, logic [8:0] x); return int'(x[7:6]) * 256 + int'(h[28:21]) + 1; endfunction
  function automatic int f_ha(logic [28:0] h); return (int'(h[6:0]) + 1) * 16; endfunction
  function automatic int f_vs(logic [31:0] v); return int'(v[15:10]) + 1; endfunction
  function automatic int f_vb(logic [31:0] v); return int'(v[23:16]); endfunction
  function automatic int f_vf(logic [31:0] v); return int'(v[31:24]); endfunction
  function automatic int f_va(logic [31:0] v, logic [8:0] x); return int'(x[8]) * 1024 + int'(v[9:0]) + 1; endfunction
  function automatic int f_div(int d); return (d < 2) ? 2 : d; endfunction

  always @(posedge clk) begin
    int ht, vt;
    ht = f_hs(m_sh_h, m_sh_x) + f_hb(m_sh_h, m_sh_x) + f_ha(m_sh_h) + f_hf(m_sh_h, m_sh_x);
    vt = f_vs(m_sh_v) + f_vb(m_sh_v) + f_va(m_sh_v, m_sh_x) + f_vf(m_sh_v);
    if (!rst_n) begin
      m_cnt <= 0; m_h <= 0; m_v <= 0; m_div <= 0;
      m_sh_h <= '0; m_sh_v <= '0; m_sh_x <= '0;
    end else if (!enable) begin
      m_cnt <= 0; m_h <= 0; m_v <= 0; m_div <= int'(clk_div);
      m_sh_h <= cfg_h; m_sh_v <= cfg_v; m_sh_x <= cfg_x;
    end else if (m_cnt == f_div(m_div) - 1) begin
      m_cnt <= 0;
      if (m_h == ht - 1) begin
        m_h <= 0;
        if (m_v == vt - 1) begin
          m_v <= 0; m_div <= int'(clk_div);
          m_sh_h <= cfg_h; m_sh_v <= cfg_v; m_sh_x <= cfg_x;
        end else m_v <= m_v + 1;
      end else m_h <= m_h + 1;
    end else m_cnt <= m_cnt + 1;
  end

  task automatic chk(string tag, string name, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: got %0d expected %0d", tag, scen, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int d, hs, hb, ha, vs, vb, va, ex_stb, ex_pclk, ex_hs, ex_vs, ex_de, ex_x, ex_y;
      logic hact, vact;
      d  = f_div(m_div);
      hs = f_hs(m_sh_h, m_sh_x); hb = f_hb(m_sh_h, m_sh_x); ha = f_ha(m_sh_h);
      vs = f_vs(m_sh_v); vb = f_vb(m_sh_v); va = f_va(m_sh_v, m_sh_x);
      hact = enable && (m_h >= hs + hb) && (m_h < hs + hb + ha);
      vact = enable && (m_v >= vs + vb) && (m_v < vs + vb + va);
      ex_stb  = (enable && m_cnt == d - 1) ? 1 : 0;
      ex_pclk = ((enable && m_cnt < d / 2) ? 1 : 0) ^ int'(inv_pclk);
      ex_hs   = ((enable && m_h < hs) ? 1 : 0) ^ int'(inv_hsync);
      ex_vs   = ((enable && m_v < vs) ? 1 : 0) ^ int'(inv_vsync);
      ex_de   = (hact && vact) ? 1 : 0;
      ex_x    = ex_de ? m_h - hs - hb : 0;
      ex_y    = ex_de ? m_v - vs - vb : 0;
      chk("R1", "pix_stb", int'(pix_stb), ex_stb);
      chk("R1", "lcd_pclk", int'(lcd_pclk), ex_pclk);
      chk("R2 R5", "hsync", int'(hsync), ex_hs);
      chk("R3 R5", "vsync", int'(vsync), ex_vs);
      chk("R4", "de", int'(de), ex_de);
      chk("R4", "pix_x", int'(pix_x), ex_x);
      chk("R4", "pix_y", int'(pix_y), ex_y);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(int ppl_m1, int hsw_m1, int hbp_m1, int hfp_m1,
                         int vsw_m1, int vbp, int vfp, int lpp_m1, int div);
    cfg_h = {8'(hfp_m1), 8'(hbp_m1), 6'(hsw_m1), 7'(ppl_m1)};
    cfg_v = {8'(vfp), 8'(vbp), 6'(vsw_m1), 10'(lpp_m1)};
    cfg_x = {1'(lpp_m1 >> 10), 2'(hfp_m1 >> 8), 2'(hbp_m1 >> 8), 4'(hsw_m1 >> 6)};
    clk_div = 8'(div);
  endtask

  task automatic strobe_gap(string tag, int exp);
    int gap = 0;
    while (pix_stb !== 1'b1) wait_cyc(1);
    wait_cyc(1); gap = 1;
    while (pix_stb !== 1'b1 && gap < 20) begin wait_cyc(1); gap++; end
    chk(tag, "strobe spacing", gap, exp);
  endtask

  initial begin
    set_cfg(0, 1, 2, 1, 1, 1, 1, 2, 2);
    wait_cyc(4);
    // R7: reset / idle state at the ports
    chk("R7", "reset de", int'(de), 0);
    chk("R7", "reset pix_stb", int'(pix_stb), 0);
    chk("R7", "reset hsync", int'(hsync), 0);
    rst_n = 1;
    wait_cyc(3);
    chk("R7", "idle pix_x", int'(pix_x), 0);
    chk("R7", "idle vsync", int'(vsync), 0);

    scen = "R2 R3 base";
    enable = 1;
    wait_cyc(700);

    // R6: change geometry mid-frame; takes effect at next frame only
    scen = "R6 mid-frame change";
    set_cfg(0, 0, 0, 2, 0, 0, 0, 1, 3);
    wait_cyc(900);

    scen = "R5 polarity";
    inv_hsync = 1; inv_vsync = 1; inv_pclk = 1;
    wait_cyc(400);
    inv_hsync = 0; inv_vsync = 0; inv_pclk = 0;

    // R7: drop enable mid-frame, restart from zero
    scen = "R7 disable";
    wait_cyc(37);
    enable = 0;
    wait_cyc(2);
    chk("R7", "disabled de", int'(de), 0);
    chk("R7", "disabled stb", int'(pix_stb), 0);
    set_cfg(1, 2, 1, 0, 2, 2, 1, 1, 1);
    wait_cyc(2);
    // R8: divisor 1 and 0 both act as 2
    scen = "R8 small divisor";
    enable = 1;
    strobe_gap("R8", 2);
    wait_cyc(1500);
    enable = 0;
    clk_div = 8'd0;
    wait_cyc(2);
    enable = 1;
    strobe_gap("R8", 2);
    wait_cyc(300);

    // wide fields using extension bits
    scen = "R2 R3 extension bits";
    enable = 0;
    set_cfg(64, 70, 256, 300, 3, 0, 2, 1, 2);
    wait_cyc(2);
    enable = 1;
    wait_cyc(24000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule